// File: doc/BRIEF.md
# Buffered Dataflow Processing Unit

A universal compute unit for a machine whose program is nothing but moves. A control unit broadcasts each move on a shared move bus. This unit watches that bus for moves that involve its own address. A move that takes its output lane as source queues the move's destination as a target for a later result. A move that carries an immediate value to one of its input lanes writes that value straight into the lane. Values produced by other units reach the input lanes over a separate data network.

Each input lane (operand A, operand B, opcode) and the output lane has its own small FIFO. The unit fires as soon as all three input lanes hold an entry and the output FIFO has room for every copy the opcode asks for. Firing pops one entry from each input lane and writes the ALU result into the output FIFO once per requested copy. The unit sends a buffered result on its transmit port in any cycle in which a target is queued. Results and targets are paired in arrival order, and each send removes one of each.

Top module: `dflow_pu`

## Requirements
- R1: After reset every FIFO is empty and `tx_valid` is 0.
- R2: A unit-relative address is `{unit, lane}` with a 2-bit lane field in the low bits: lane 0 = operand A, 1 = operand B, 2 = opcode, 3 = output. A data-network write (`dn_valid`) to `{UNIT, lane}` with lane 0 to 2 pushes `dn_data` into that lane. A write to another unit's address has no effect.
- R3: A move with `mv_imm`=1 and `mv_dst` = `{UNIT, lane}` with lane 0 to 2 pushes `mv_val` into that lane.
- R4: A move with `mv_imm`=0 and `mv_src` = `{UNIT, 3}` queues `mv_dst` as a target. A move whose source is another unit's output queues nothing.
- R5: The unit fires only when lanes A, B and opcode are all non-empty. Firing pops one entry from each of the three lanes.
- R6: Opcode bits [3:0] select the operation and bits [5:4] hold the copy count minus one, so 1 to 4 copies of the result enter the output FIFO.
- R7: The unit does not fire while the output FIFO has fewer free slots than the copy count. Results are never lost or overwritten.
- R8: `tx_valid` is 1 only while both a result and a target are queued. Each cycle with `tx_valid` high sends `tx_data` to `tx_dst` and removes both entries. Results pair with targets in FIFO order.
- R9: Operations, on 32-bit values: 0 add, 1 sub (A-B), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right (shift amount B[4:0]), 7 signed set-less-than (1 if A<B, else 0). Any other code gives 0.
- R10: Suppose the last missing input is written at clock edge k and a target is already queued. The unit fires at edge k+1, and the result is on the transmit port after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_valid | input | 1 | Move bus carries a move |
| mv_imm | input | 1 | Move carries an immediate value |
| mv_src | input | UW+2 | Move source address |
| mv_dst | input | UW+2 | Move destination address |
| mv_val | input | W | Immediate value |
| dn_valid | input | 1 | Data network carries a value |
| dn_dst | input | UW+2 | Data network destination address |
| dn_data | input | W | Data network value |
| tx_valid | output | 1 | A result is being sent this cycle |
| tx_dst | output | UW+2 | Destination of the result |
| tx_data | output | W | Result value |

## Verification
The hardest situation to reach is a firing that is blocked only by output space. All inputs are present but the output FIFO lacks room for the copy count. The stimulus gets there by firing a three-copy operation with no targets queued, then queueing a two-copy operation. Targets are then released one at a time, so the first send frees exactly enough room. A missing space check would overwrite the oldest result, and the scoreboard would see a wrong value.

// File: rtl/dflow_pu.sv
module dflow_pu #(
  parameter int W = 32,
  parameter int UW = 4,
  parameter int DEPTH = 4,
  parameter logic [UW-1:0] UNIT = 4'd5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mv_valid,
  input  logic            mv_imm,
  input  logic [UW+1:0]   mv_src,
  input  logic [UW+1:0]   mv_dst,
  input  logic [W-1:0]    mv_val,
  input  logic            dn_valid,
  input  logic [UW+1:0]   dn_dst,
  input  logic [W-1:0]    dn_data,
  output logic            tx_valid,
  output logic [UW+1:0]   tx_dst,
  output logic [W-1:0]    tx_data
);
  localparam int AW = UW + 2;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(W);
  localparam int MAXC = 4;

  logic [W-1:0]  iq [3][DEPTH];
  logic [PW-1:0] iwp [3];
  logic [PW-1:0] irp [3];
  logic [CW-1:0] icnt [3];
  logic [2:0]    wr;
  logic [W-1:0]  wdat [3];

  logic [W-1:0]  oq [DEPTH];
  logic [PW-1:0] owp, orp;
  logic [CW-1:0] ocnt;
  logic [AW-1:0] tq [DEPTH];
  logic [PW-1:0] twp, trp;
  logic [CW-1:0] tcnt;

  logic [W-1:0]  a, b, opc, res;
  logic [CW-1:0] ncopy;
  logic          fire, send, tgt_wr;

  always_comb
    for (int i = 0; i < 3; i++) begin
      logic hit_mv, hit_dn;
      hit_mv  = mv_valid && mv_imm && mv_dst == {UNIT, 2'(i)};
      hit_dn  = dn_valid && dn_dst == {UNIT, 2'(i)};
      wr[i]   = (hit_mv || hit_dn) && icnt[i] != CW'(DEPTH);
      wdat[i] = hit_mv ? mv_val : dn_data;
    end

  assign a      = iq[0][irp[0]];
  assign b      = iq[1][irp[1]];
  assign opc    = iq[2][irp[2]];
  assign ncopy  = CW'(opc[5:4]) + CW'(1);
  assign fire   = icnt[0] != 0 && icnt[1] != 0 && icnt[2] != 0 &&
                  (CW'(DEPTH) - ocnt) >= ncopy;
  assign send   = ocnt != 0 && tcnt != 0;
  assign tgt_wr = mv_valid && !mv_imm && mv_src == {UNIT, 2'd3} &&
                  tcnt != CW'(DEPTH);

  always_comb
    case (opc[3:0])
      4'd0: res = a + b;
      4'd1: res = a - b;
      4'd2: res = a & b;
      4'd3: res = a | b;
      4'd4: res = a ^ b;
      4'd5: res = a << b[SW-1:0];
      4'd6: res = a >> b[SW-1:0];
      4'd7: res = W'($signed(a) < $signed(b));
      default: res = '0;
    endcase

  assign tx_valid = send;
  assign tx_dst   = tq[trp];
  assign tx_data  = oq[orp];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        iwp[i]  <= '0;
        irp[i]  <= '0;
        icnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (wr[i]) begin
          iq[i][iwp[i]] <= wdat[i];
          iwp[i] <= iwp[i] + PW'(1);
        end
        if (fire) irp[i] <= irp[i] + PW'(1);
        icnt[i] <= icnt[i] + CW'(wr[i]) - CW'(fire);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      owp <= '0; orp <= '0; ocnt <= '0;
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (fire) begin
        for (int j = 0; j < MAXC; j++)
          if (CW'(j) < ncopy) oq[owp + PW'(j)] <= res;
        owp <= owp + PW'(ncopy);
      end
      if (tgt_wr) begin
        tq[twp] <= mv_dst;
        twp <= twp + PW'(1);
      end
      if (send) begin
        orp <= orp + PW'(1);
        trp <= trp + PW'(1);
      end
      ocnt <= ocnt + (fire ? ncopy : CW'(0)) - CW'(send);
      tcnt <= tcnt + CW'(tgt_wr) - CW'(send);
    end

  // R7
  out_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocnt <= CW'(DEPTH));
  // R6
  copy_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !send |=> ocnt == $past(ocnt) + $past(ncopy));
  // R8
  tgt_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tgt_wr |=> tcnt == $past(tcnt) - CW'(1));
  // R5
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icnt[0] != 0 && !fire && !wr[0] |=> $stable(icnt[0]));
  // R2
  in_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icnt[0] <= CW'(DEPTH) && icnt[1] <= CW'(DEPTH) && icnt[2] <= CW'(DEPTH));
endmodule

// File: tb/sim_dflow_pu.sv
module sim_dflow_pu;
  localparam int W = 32, UW = 4;
  localparam logic [UW-1:0] UNIT = 4'd5;

  logic clk = 0, rst_n = 0;
  logic mv_valid = 0, mv_imm = 0, dn_valid = 0;
  logic [UW+1:0] mv_src = '0, mv_dst = '0, dn_dst = '0;
  logic [W-1:0] mv_val = '0, dn_data = '0;
  logic tx_valid;
  logic [UW+1:0] tx_dst;
  logic [W-1:0] tx_data;

  int checks = 0, fails = 0, nseen = 0;
  bit done = 0;
  logic [W-1:0]    res_q[$];
  logic [UW+1:0]   tgt_q[$];
  logic [UW+W+1:0] exp_q[$];

  always #5 clk = ~clk;

  dflow_pu #(.W(W), .UW(UW), .DEPTH(4), .UNIT(UNIT)) u0 (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] alu(logic [3:0] op, logic [W-1:0] x, logic [W-1:0] y);
    case (op)
      0: return x + y;
      1: return x - y;
      2: return x & y;
      3: return x | y;
      4: return x ^ y;
      5: return x << y[4:0];
      6: return x >> y[4:0];
      7: return ($signed(x) < $signed(y)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic void pair();
    while (res_q.size() > 0 && tgt_q.size() > 0)
      exp_q.push_back({tgt_q.pop_front(), res_q.pop_front()});
  endfunction

  task automatic dn(logic [UW-1:0] unit, logic [1:0] lane, logic [W-1:0] v);
    @(negedge clk);
    dn_valid = 1; dn_dst = {unit, lane}; dn_data = v;
    @(posedge clk); #1 dn_valid = 0;
  endtask

  task automatic imm(logic [1:0] lane, logic [W-1:0] v);
    @(negedge clk);
    mv_valid = 1; mv_imm = 1; mv_dst = {UNIT, lane}; mv_val = v;
    @(posedge clk); #1 mv_valid = 0; mv_imm = 0;
  endtask

  task automatic tgt(logic [UW-1:0] src_unit, logic [UW+1:0] d);
    @(negedge clk);
    mv_valid = 1; mv_imm = 0; mv_src = {src_unit, 2'd3}; mv_dst = d;
    @(posedge clk); #1 mv_valid = 0;
    if (src_unit == UNIT) begin tgt_q.push_back(d); pair(); end
  endtask

  task automatic issue(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] op, logic [1:0] cm1, bit use_imm);
    if (use_imm) begin imm(0, x); imm(1, y); imm(2, {26'd0, cm1, op}); end
    else begin dn(UNIT, 0, x); dn(UNIT, 1, y); dn(UNIT, 2, {26'd0, cm1, op}); end
    for (int c = 0; c <= cm1; c++) res_q.push_back(alu(op, x, y));
    pair();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk)
    if (rst_n && tx_valid) begin
      nseen++;
      if (exp_q.size() == 0) chk(0, "R8 unexpected send", {26'd0, tx_dst, tx_data}, 0);
      else begin
        logic [UW+W+1:0] e;
        e = exp_q.pop_front();
        chk({tx_dst, tx_data} == e, "R8/R9 result/target", {26'd0, tx_dst, tx_data}, {26'd0, e});
      end
    end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] av[9], bv[9];
    logic [3:0] ov[9];
    int s0;
    av = '{32'd100, 32'd7, 32'hF0F0_1234, 32'h0000_00F0, 32'hAAAA_5555, 32'h0000_0003, 32'h8000_0000, 32'hFFFF_FFFE, 32'd9};
    bv = '{32'd23,  32'd20, 32'h0FF0_FF00, 32'h0000_0F0F, 32'hFFFF_0000, 32'd4, 32'd31, 32'd1, 32'd9};
    ov = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd11};
    idle(2);
    // R1 reset state
    chk(tx_valid == 0, "R1 tx_valid in reset", tx_valid, 0);
    rst_n = 1;
    idle(2);
    chk(tx_valid == 0, "R1 tx_valid after reset", tx_valid, 0);

    // R9 R2 each operation via the data network, one copy
    for (int i = 0; i < 9; i++) begin
      issue(av[i], bv[i], ov[i], 2'd0, 0);
      tgt(UNIT, 6'(i + 8));
      idle(3);
    end

    // R3 immediate moves
    issue(32'd40, 32'd2, 4'd1, 2'd0, 1);
    tgt(UNIT, 6'h21);
    idle(3);

    // R6 four copies, four targets
    issue(32'd5, 32'd6, 4'd0, 2'd3, 0);
    for (int i = 0; i < 4; i++) tgt(UNIT, 6'(i + 40));
    idle(3);

    // R8 results without targets are held; R4 foreign move ignored; R2 foreign write ignored
    s0 = nseen;
    issue(32'd1, 32'd2, 4'd3, 2'd1, 0);
    idle(4);
    tgt(4'd6, 6'h11);
    dn(4'd6, 2'd0, 32'hDEAD_BEEF);
    idle(4);
    chk(nseen == s0, "R8 R4 no send without own target", nseen, s0);
    tgt(UNIT, 6'h12);
    tgt(UNIT, 6'h13);
    idle(3);
    chk(nseen == s0 + 2, "R8 held results delivered", nseen, s0 + 2);
    // after foreign write, next operation must use the correct A
    issue(32'd50, 32'd8, 4'd0, 2'd0, 0);
    tgt(UNIT, 6'h14);
    idle(3);

    // R7 firing blocked by output space
    s0 = nseen;
    issue(32'd11, 32'd0, 4'd3, 2'd2, 0);
    idle(2);
    issue(32'd22, 32'd0, 4'd3, 2'd1, 0);
    idle(3);
    chk(nseen == s0, "R7 no send while waiting", nseen, s0);
    for (int i = 0; i < 5; i++) begin tgt(UNIT, 6'(i + 48)); idle(2); end
    chk(nseen == s0 + 5, "R7 all copies delivered", nseen, s0 + 5);

    // R10 latency from last input
    tgt(UNIT, 6'h3E);
    dn(UNIT, 0, 32'd3);
    dn(UNIT, 1, 32'd4);
    res_q.push_back(32'd7);
    pair();
    dn(UNIT, 2, 32'd0);
    @(negedge clk);
    chk(tx_valid == 0, "R10 not before fire edge", tx_valid, 0);
    @(negedge clk);
    chk(tx_valid == 1, "R10 send right after fire edge", tx_valid, 1);
    idle(3);

    chk(exp_q.size() == 0 && res_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule